// File: doc/BRIEF.md
# Receive Packet Admission Counter

This block sits between the receive path of a network MAC and its packet buffer. Each time a frame begins to arrive it decides whether the frame may enter the buffer. It also counts the packets that are stored and still waiting for firmware. A frame is refused when the pending count has reached its ceiling or when the buffer manager reports no free space. A frame that was admitted is abandoned if the memory arbiter signals that the receive writes could not be served in time. Each of these three outcomes raises one receive error pulse and records a cause code. A bandwidth fault also sets a sticky status flag, which firmware clears.

Firmware pulses a consume strobe after it has processed a stored packet, and this lowers the count. The block also holds the buffer read pointer that firmware writes one byte at a time. A write to the low byte goes into a shadow register. The pointer changes only when the high byte is written, so the pointer never shows a mix of an old byte and a new byte.

Top module: `rxadm_top`

## Requirements
- R1: After reset, the pending count, busy, admit, error, bandwidth flag, cause code and read pointer are all zero.
- R2: A frame start while idle, with the count below 255 and free space reported, gives a one-cycle admit pulse on the next cycle and makes the block busy.
- R3: A frame start while idle, with the count below 255 and no free space, gives a receive error pulse on the next cycle with cause code 1, and no admit pulse.
- R4: A frame start while the count is 255 gives a receive error pulse with cause code 2 and no admit pulse, whatever the free-space input says. This cause takes priority over cause 1.
- R5: A bandwidth fault while busy aborts the frame: on the next cycle there is a receive error pulse with cause code 3, the bandwidth flag is set and busy clears, and the count does not change. A bandwidth fault while idle has no effect.
- R6: A frame end while busy, with no bandwidth fault in the same cycle, clears busy and raises the count by one on the next cycle. A frame end while idle has no effect.
- R7: A consume strobe lowers the count by one on the next cycle. A consume strobe when the count is 0 is ignored.
- R8: When a frame end raises the count in the same cycle as a consume strobe lowers it, and the count is between 1 and 254, the count stays the same.
- R9: The bandwidth flag stays set until a clear strobe. When a set and a clear arrive in the same cycle, the set wins.
- R10: A low-byte write only loads the shadow register. A high-byte write loads the read pointer with {high byte, shadow} on the next cycle.
- R11: A frame start while busy is ignored: there is no admit pulse and no error pulse.
- R12: The count never wraps from 255 to 0 and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | A new frame begins arriving |
| frm_end | input | 1 | The current frame completed cleanly |
| buf_space | input | 1 | The buffer manager has room for a frame |
| bw_fault | input | 1 | The memory arbiter could not serve receive writes |
| pkt_consume | input | 1 | Firmware has finished with one stored packet |
| bw_flag_clr | input | 1 | Firmware clears the bandwidth flag |
| ptr_lo_we | input | 1 | Write the low byte of the read pointer |
| ptr_hi_we | input | 1 | Write the high byte and commit the read pointer |
| ptr_wdata | input | 8 | Byte written to the read pointer |
| frm_admit_o | output | 1 | One-cycle pulse: the frame was admitted |
| rx_err_o | output | 1 | One-cycle pulse: the frame was refused or aborted |
| err_cause_o | output | 2 | Last error cause: 1 no space, 2 count full, 3 bandwidth |
| frm_busy_o | output | 1 | An admitted frame is in progress |
| bw_flag_o | output | 1 | Sticky bandwidth-fault status |
| pend_cnt_o | output | 8 | Number of pending packets |
| rdptr_o | output | 16 | Committed buffer read pointer |

## Verification
The checker watches several rules on every cycle. The count never wraps, it never moves by more than one, and it does not go below zero on a consume. An error pulse always carries a nonzero cause and never comes with an admit. A bandwidth abort always leaves the flag set. The read pointer stays still unless a high-byte write came just before. The bench's scenarios are needed for the rest: the exact count after filling to 255 and draining back to 0, the priority of the full-count cause over the no-space cause, the cancellation of a frame end by a consume in the same cycle, and the shadow behaviour of low-byte writes.

// File: rtl/rxadm_pkg.sv
package rxadm_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_NO_SPACE = 2'd1,
        CAUSE_CNT_FULL = 2'd2,
        CAUSE_BW       = 2'd3
    } rx_cause_e;

    typedef struct packed {
        logic      busy;
        logic      admit;
        logic      err;
        rx_cause_e cause;
        logic      bw_flag;
    } ctl_state_t;

endpackage

// File: rtl/rxadm_pend_cnt.sv
module rxadm_pend_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             do_inc, do_dec;

    always_comb begin
        // saturate at both ends: no inc at max, no dec at zero
        do_inc = inc_i && (cnt_q != CNT_MAX);
        do_dec = dec_i && (cnt_q != '0);
        cnt_d  = cnt_q;
        if (do_inc && !do_dec) begin
            cnt_d = cnt_q + CNT_ONE;
        end else if (do_dec && !do_inc) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/rxadm_frame_ctl.sv
module rxadm_frame_ctl
    import rxadm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frm_start,
    input  logic      frm_end,
    input  logic      buf_space,
    input  logic      bw_fault,
    input  logic      bw_flag_clr,
    input  logic      cnt_full,
    output logic      commit_o,
    output logic      admit_o,
    output logic      err_o,
    output rx_cause_e cause_o,
    output logic      busy_o,
    output logic      bw_flag_o
);
    ctl_state_t st_d, st_q;
    logic       commit_d;

    always_comb begin
        st_d       = st_q;
        st_d.admit = 1'b0;
        st_d.err   = 1'b0;
        commit_d   = 1'b0;

        if (bw_flag_clr) begin
            st_d.bw_flag = 1'b0;
        end

        if (st_q.busy) begin
            // a fault outranks a clean end in the same cycle
            if (bw_fault) begin
                st_d.busy    = 1'b0;
                st_d.err     = 1'b1;
                st_d.cause   = CAUSE_BW;
                st_d.bw_flag = 1'b1;
            end else if (frm_end) begin
                st_d.busy = 1'b0;
                commit_d  = 1'b1;
            end
        end else if (frm_start) begin
            if (cnt_full) begin
                st_d.err   = 1'b1;
                st_d.cause = CAUSE_CNT_FULL;
            end else if (!buf_space) begin
                st_d.err   = 1'b1;
                st_d.cause = CAUSE_NO_SPACE;
            end else begin
                st_d.busy  = 1'b1;
                st_d.admit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o  = commit_d;
    assign admit_o   = st_q.admit;
    assign err_o     = st_q.err;
    assign cause_o   = st_q.cause;
    assign busy_o    = st_q.busy;
    assign bw_flag_o = st_q.bw_flag;

endmodule

// File: rtl/rxadm_ptr_latch.sv
module rxadm_ptr_latch #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] ptr_o
);
    typedef struct packed {
        logic [BYTE_W-1:0]   shadow;
        logic [2*BYTE_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (lo_we) begin
            ps_d.shadow = wdata;
        end
        // the high-byte write commits whatever the shadow held before this edge
        if (hi_we) begin
            ps_d.ptr = {wdata, ps_q.shadow};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign ptr_o = ps_q.ptr;

endmodule

// File: rtl/rxadm_top.sv
module rxadm_top
    import rxadm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic              buf_space,
    input  logic              bw_fault,
    input  logic              pkt_consume,
    input  logic              bw_flag_clr,
    input  logic              ptr_lo_we,
    input  logic              ptr_hi_we,
    input  logic [BYTE_W-1:0] ptr_wdata,
    output logic              frm_admit_o,
    output logic              rx_err_o,
    output logic [1:0]        err_cause_o,
    output logic              frm_busy_o,
    output logic              bw_flag_o,
    output logic [CNT_W-1:0]  pend_cnt_o,
    output logic [PTR_W-1:0]  rdptr_o
);
    logic      commit;
    logic      cnt_full;
    rx_cause_e cause;

    rxadm_frame_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_start  (frm_start),
        .frm_end    (frm_end),
        .buf_space  (buf_space),
        .bw_fault   (bw_fault),
        .bw_flag_clr(bw_flag_clr),
        .cnt_full   (cnt_full),
        .commit_o   (commit),
        .admit_o    (frm_admit_o),
        .err_o      (rx_err_o),
        .cause_o    (cause),
        .busy_o     (frm_busy_o),
        .bw_flag_o  (bw_flag_o)
    );

    rxadm_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (commit),
        .dec_i (pkt_consume),
        .cnt_o (pend_cnt_o),
        .full_o(cnt_full)
    );

    rxadm_ptr_latch #(.BYTE_W(BYTE_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .lo_we(ptr_lo_we),
        .hi_we(ptr_hi_we),
        .wdata(ptr_wdata),
        .ptr_o(rdptr_o)
    );

    assign err_cause_o = cause;

endmodule

// File: rtl/rxadm_chk.sv
module rxadm_chk #(
    parameter int CNT_W = 8,
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_start,
    input logic             buf_space,
    input logic             pkt_consume,
    input logic             ptr_hi_we,
    input logic             frm_admit_o,
    input logic             rx_err_o,
    input logic [1:0]       err_cause_o,
    input logic             frm_busy_o,
    input logic             bw_flag_o,
    input logic [CNT_W-1:0] pend_cnt_o,
    input logic [PTR_W-1:0] rdptr_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R12
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt_o == CMAX) |=> (pend_cnt_o != '0));

    // R12
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt_o == $past(pend_cnt_o)) ||
        (pend_cnt_o == $past(pend_cnt_o) + CONE) ||
        (pend_cnt_o == $past(pend_cnt_o) - CONE));

    // R7
    dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt_o == '0 && pkt_consume) |=> (pend_cnt_o <= CONE));

    // R3
    err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_o |-> (err_cause_o != 2'd0));

    // R2
    admit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_admit_o && rx_err_o));

    // R3
    no_admit_nospace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && !frm_busy_o && !buf_space) |=> !frm_admit_o);

    // R5
    bw_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_o && err_cause_o == 2'd3) |-> bw_flag_o);

    // R11
    busy_start_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && frm_busy_o) |=> (!frm_admit_o && !(rx_err_o && err_cause_o != 2'd3)));

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_hi_we |=> $stable(rdptr_o));

endmodule

bind rxadm_top rxadm_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_rxadm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_start  (frm_start),
    .buf_space  (buf_space),
    .pkt_consume(pkt_consume),
    .ptr_hi_we  (ptr_hi_we),
    .frm_admit_o(frm_admit_o),
    .rx_err_o   (rx_err_o),
    .err_cause_o(err_cause_o),
    .frm_busy_o (frm_busy_o),
    .bw_flag_o  (bw_flag_o),
    .pend_cnt_o (pend_cnt_o),
    .rdptr_o    (rdptr_o)
);

// File: tb/rxadm_top_bench.sv
module rxadm_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frm_start, frm_end, buf_space, bw_fault, pkt_consume, bw_flag_clr;
    logic        ptr_lo_we, ptr_hi_we;
    logic [7:0]  ptr_wdata;
    logic        frm_admit_o, rx_err_o, frm_busy_o, bw_flag_o;
    logic [1:0]  err_cause_o;
    logic [7:0]  pend_cnt_o;
    logic [15:0] rdptr_o;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxadm_top u_rxadm_top (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
        .buf_space(buf_space), .bw_fault(bw_fault), .pkt_consume(pkt_consume),
        .bw_flag_clr(bw_flag_clr), .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we),
        .ptr_wdata(ptr_wdata), .frm_admit_o(frm_admit_o), .rx_err_o(rx_err_o),
        .err_cause_o(err_cause_o), .frm_busy_o(frm_busy_o), .bw_flag_o(bw_flag_o),
        .pend_cnt_o(pend_cnt_o), .rdptr_o(rdptr_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        frm_start = 0; frm_end = 0; bw_fault = 0; pkt_consume = 0;
        bw_flag_clr = 0; ptr_lo_we = 0; ptr_hi_we = 0; ptr_wdata = 8'h00;
    endtask

    // one start cycle; outputs from that edge are checked by the caller
    task automatic start_frame(input logic space);
        buf_space = space; frm_start = 1; step(); idle_inputs();
    endtask

    task automatic full_frame();
        start_frame(1'b1);
        chk("R2 admit", frm_admit_o, 1);
        chk("R2 busy", frm_busy_o, 1);
        frm_end = 1; step(); idle_inputs();
        exp_cnt++;
        chk("R6 count", pend_cnt_o, exp_cnt);
        chk("R6 busy clear", frm_busy_o, 0);
    endtask

    initial begin
        #150000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; buf_space = 1; idle_inputs();
        repeat (3) step();
        rst_n = 1; step();
        // R1
        chk("R1 count", pend_cnt_o, 0);
        chk("R1 busy", frm_busy_o, 0);
        chk("R1 err", rx_err_o, 0);
        chk("R1 admit", frm_admit_o, 0);
        chk("R1 cause", err_cause_o, 0);
        chk("R1 flag", bw_flag_o, 0);
        chk("R1 ptr", rdptr_o, 0);

        // R7 consume at zero
        pkt_consume = 1; step(); idle_inputs();
        chk("R7 floor", pend_cnt_o, 0);

        // R6 end while idle, R5 fault while idle
        frm_end = 1; bw_fault = 1; step(); idle_inputs();
        chk("R6 idle end", pend_cnt_o, 0);
        chk("R5 idle fault flag", bw_flag_o, 0);
        chk("R5 idle fault err", rx_err_o, 0);

        // R3 no space
        start_frame(1'b0);
        chk("R3 err", rx_err_o, 1);
        chk("R3 cause", err_cause_o, 1);
        chk("R3 no admit", frm_admit_o, 0);
        chk("R3 busy", frm_busy_o, 0);

        // R11 start while busy
        start_frame(1'b1);
        chk("R2 admit", frm_admit_o, 1);
        start_frame(1'b0);
        chk("R11 admit", frm_admit_o, 0);
        chk("R11 err", rx_err_o, 0);
        chk("R11 busy", frm_busy_o, 1);

        // R5 fault aborts, fault outranks end
        bw_fault = 1; frm_end = 1; step(); idle_inputs();
        chk("R5 err", rx_err_o, 1);
        chk("R5 cause", err_cause_o, 3);
        chk("R5 flag", bw_flag_o, 1);
        chk("R5 busy", frm_busy_o, 0);
        chk("R5 count", pend_cnt_o, exp_cnt);
        step();
        chk("R5 pulse", rx_err_o, 0);
        chk("R9 sticky", bw_flag_o, 1);

        // R9 clear and set together: set wins
        start_frame(1'b1);
        bw_fault = 1; bw_flag_clr = 1; step(); idle_inputs();
        chk("R9 set wins", bw_flag_o, 1);
        bw_flag_clr = 1; step(); idle_inputs();
        chk("R9 clear", bw_flag_o, 0);

        // R2 / R6 fill to the ceiling
        for (int i = 0; i < 255; i++) full_frame();
        chk("R12 top", pend_cnt_o, 255);

        // R4 full cause, with and without space
        start_frame(1'b1);
        chk("R4 err", rx_err_o, 1);
        chk("R4 cause", err_cause_o, 2);
        chk("R4 no admit", frm_admit_o, 0);
        start_frame(1'b0);
        chk("R4 priority", err_cause_o, 2);
        chk("R12 no wrap", pend_cnt_o, 255);

        // R7 drain down
        for (int i = 0; i < 254; i++) begin
            pkt_consume = 1; step(); idle_inputs();
            exp_cnt--;
            chk("R7 dec", pend_cnt_o, exp_cnt);
        end

        // R8 end and consume together at count 1
        start_frame(1'b1);
        frm_end = 1; pkt_consume = 1; step(); idle_inputs();
        chk("R8 hold", pend_cnt_o, 1);
        pkt_consume = 1; step(); idle_inputs();
        chk("R7 to zero", pend_cnt_o, 0);
        pkt_consume = 1; step(); idle_inputs();
        chk("R7 floor again", pend_cnt_o, 0);

        // R10 pointer shadow
        for (int v = 0; v < 16; v++) begin
            ptr_lo_we = 1; ptr_wdata = 8'(v * 17 + 3); step(); idle_inputs();
            chk("R10 lo only", rdptr_o, (v == 0) ? 0 : (((v - 1) * 29 + 1) & 255) * 256 + ((v - 1) * 17 + 3));
            ptr_hi_we = 1; ptr_wdata = 8'(v * 29 + 1); step(); idle_inputs();
            chk("R10 commit", rdptr_o, ((v * 29 + 1) & 255) * 256 + ((v * 17 + 3) & 255));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule